// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz clock-enable pulse into a periodic interrupt whose rate is picked by a 4-bit rate code. A 15-bit base count runs freely on the time-base pulse and is never restarted. The rate code selects a power-of-two period. A tick is produced on every base step where the count lands on a multiple of that period, so the ticks always stay phase-locked to the time base, whatever the moment at which the code was written.

Each tick is one clock cycle wide. On the same clock edge it sets two sticky status flags: a periodic flag and a summary flag that serves as the interrupt request. A clear strobe, which the surrounding register logic issues when the status register is read, drops both flags unless a tick lands in the same cycle. The rate code and the enable are used combinationally on every base step, so a new code or a change of enable applies to the very next step. No restart sequence is needed.

Top module: `prd_irq_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the base count returns to zero and `tick`, `per_flag` and `irq_flag` are all low after that edge.
- R2: Rate code 0 produces no ticks, whatever the enable.
- R3: With `pie_en` low, no ticks are produced for any rate code.
- R4: Rate code 1 gives a period of 128 base steps and code 2 gives a period of 256 base steps. These are the periods of codes 8 and 9.
- R5: Rate codes 3 through 15 give a period of 2^(code-1) base steps. For example, code 3 gives 4 steps and code 15 gives 16384 steps.
- R6: The base count starts at zero after reset and wraps modulo 32768. A tick occurs exactly on the steps where the new count is a multiple of the period.
- R7: `tick` rises only in the clock cycle that follows a clock with `tb_en` high, and it is high for exactly one cycle.
- R8: The edge that raises `tick` also sets `per_flag` and `irq_flag` high. Both flags then stay high until they are cleared.
- R9: A clock edge with `flag_clr` high clears both flags, unless the same edge raises `tick`. In that case the set wins and both flags are high.
- R10: A change of `rate_code` or `pie_en` applies to the next base step. The base count is not restarted, so after a change the first tick falls on the next multiple of the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_en | input | 1 | One-cycle enable pulse at the 32768 Hz time-base rate |
| rate_code | input | 4 | Rate select; 0 disables ticks |
| pie_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Clear strobe for the status flags (the status read) |
| tick | output | 1 | One-cycle periodic tick |
| per_flag | output | 1 | Sticky periodic flag |
| irq_flag | output | 1 | Sticky summary flag / interrupt request |

## Verification
A tick setting the flags and the clear strobe dropping them can fall on the same clock edge. The bench provokes this by pulsing `flag_clr` every fifth cycle while the shortest period of 4 steps runs with the time base enabled on every cycle, so the clears repeatedly land on tick edges and on the edges between ticks. A behavioural model applies set-over-clear and is compared with both flags on every clock. It expects the flags high after a colliding edge and low after a clear-only edge.

// File: rtl/prd_irq_pkg.sv
// Shared constants and helpers for the periodic interrupt rate generator.
// Assumes a 4-bit rate code in which codes 1 and 2 are folded onto 8 and 9.
package prd_irq_pkg;

    localparam int RATE_W      = 4;   // width of the rate select code
    localparam int BASE_W      = 15;  // width of the free-running base count
    localparam int FOLD_LIMIT  = 2;   // codes up to this value are folded
    localparam int FOLD_OFFSET = 7;   // amount added to folded codes
    localparam int FLAG_N      = 2;   // number of status flags driven by a tick

    // Index of each sticky status flag.
    typedef enum int {
        FLG_PERIODIC = 0,
        FLG_SUMMARY  = 1
    } flag_idx_e;

    // Maps a raw rate code to the effective code (1->8, 2->9, others unchanged).
    function automatic logic [RATE_W-1:0] fold_rate(input logic [RATE_W-1:0] code);
        if (code != '0 && code <= RATE_W'(FOLD_LIMIT))
            return code + RATE_W'(FOLD_OFFSET);
        else
            return code;
    endfunction

endpackage

// File: rtl/prd_base_counter.sv
// Free-running base counter of the time base.
// It advances by one on every clock that carries the time-base enable and
// wraps at 2**W. It is never restarted except by reset. The output is the
// value the count takes at the coming edge, so downstream logic can judge
// the step that is about to happen.
module prd_base_counter #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    output logic [W-1:0] cnt_next
);

    logic [W-1:0] cnt_q;

    // Value of the count after this step (wraps naturally at 2**W).
    always_comb begin
        cnt_next = step_en ? cnt_q + W'(1) : cnt_q;
    end

    // Holds the count; zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next;
    end

endmodule

// File: rtl/prd_rate_decode.sv
// Rate decode: turns the rate code and the enable into an "active" flag and
// an alignment mask of (period - 1). Purely combinational, so a rate or
// enable change applies to the very next base step. Assumes every folded
// code minus one is below the base count width.
module prd_rate_decode
    import prd_irq_pkg::*;
#(
    parameter int CW = RATE_W,
    parameter int W  = BASE_W
) (
    input  logic [CW-1:0] rate_code,
    input  logic          enable,
    output logic          active,
    output logic [W-1:0]  align_mask
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [CW-1:0] eff_code;
    logic [CW-1:0] shamt;

    // Folds the low codes and derives the exponent of the period.
    always_comb begin
        eff_code = fold_rate(rate_code);
        shamt    = (eff_code == '0) ? '0 : eff_code - CW'(1);
    end

    // Active only with a non-zero code and the enable set; the mask is period-1.
    always_comb begin
        active     = enable && (rate_code != '0);
        align_mask = (ONE << shamt) - ONE;
    end

endmodule

// File: rtl/prd_tick_gen.sv
// Tick generator: marks the base steps whose new count is a multiple of the
// period. The tick is registered, so it is high in the cycle after the
// qualifying time-base pulse and lasts one cycle. The pre-register strobe
// is also exported so the status flags update on the same edge.
module prd_tick_gen #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         active,
    input  logic [W-1:0] align_mask,
    input  logic [W-1:0] cnt_next,
    output logic         tick_set,
    output logic         tick_q
);

    // A step lands on a period boundary when the masked bits of the new count are zero.
    always_comb begin
        tick_set = step_en && active && ((cnt_next & align_mask) == '0);
    end

    // Registers the one-cycle tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= 1'b0;
        else
            tick_q <= tick_set;
    end

endmodule

// File: rtl/prd_status_flags.sv
// Sticky status flags set by the tick strobe.
// Every flag is set by a tick and cleared by the clear strobe. When both
// happen on the same edge, the set wins, so no tick is ever lost.
module prd_status_flags
    import prd_irq_pkg::*;
#(
    parameter int N = FLAG_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_set,
    input  logic         clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Set-over-clear sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (tick_set)
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/prd_irq_gen.sv
// Top of the periodic interrupt rate generator.
// It divides a 32768 Hz clock-enable pulse by a power of two chosen by the
// rate code. Ticks are aligned to a free-running base count. Each tick sets
// the periodic and summary flags. Assumes tb_en is a one-cycle pulse
// synchronous to clk.
module prd_irq_gen
    import prd_irq_pkg::*;
#(
    parameter int CW = RATE_W,
    parameter int W  = BASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tb_en,
    input  logic [CW-1:0] rate_code,
    input  logic          pie_en,
    input  logic          flag_clr,
    output logic          tick,
    output logic          per_flag,
    output logic          irq_flag
);

    logic [W-1:0]      cnt_next;
    logic              active;
    logic [W-1:0]      align_mask;
    logic              tick_set;
    logic [FLAG_N-1:0] flags;

    prd_base_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (tb_en),
        .cnt_next (cnt_next)
    );

    prd_rate_decode #(.CW(CW), .W(W)) u_dec (
        .rate_code  (rate_code),
        .enable     (pie_en),
        .active     (active),
        .align_mask (align_mask)
    );

    prd_tick_gen #(.W(W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (tb_en),
        .active     (active),
        .align_mask (align_mask),
        .cnt_next   (cnt_next),
        .tick_set   (tick_set),
        .tick_q     (tick)
    );

    prd_status_flags #(.N(FLAG_N)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_set (tick_set),
        .clr      (flag_clr),
        .flags    (flags)
    );

    // Maps the flag vector onto the named outputs.
    always_comb begin
        per_flag = flags[FLG_PERIODIC];
        irq_flag = flags[FLG_SUMMARY];
    end

endmodule

// File: rtl/prd_irq_gen_chk.sv
// Assertion checker for prd_irq_gen, attached by bind. Observes ports only.
module prd_irq_gen_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tb_en,
    input logic [CW-1:0] rate_code,
    input logic          pie_en,
    input logic          flag_clr,
    input logic          tick,
    input logic          per_flag,
    input logic          irq_flag
);

    // R7
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7
    tick_needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> $past(tb_en));

    // R2
    tick_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> $past(rate_code) != '0);

    // R3
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> $past(pie_en));

    // R8
    tick_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (per_flag && irq_flag));

    // R9
    clear_drops_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !tick) |=> (!per_flag && !irq_flag) || tick);

    // R8
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_flag && !flag_clr) |=> per_flag);

endmodule

bind prd_irq_gen prd_irq_gen_chk #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_en     (tb_en),
    .rate_code (rate_code),
    .pie_en    (pie_en),
    .flag_clr  (flag_clr),
    .tick      (tick),
    .per_flag  (per_flag),
    .irq_flag  (irq_flag)
);

// File: tb/prd_irq_gen_tb_top.sv
// Bench for prd_irq_gen: behavioural reference model compared on every clock.
module prd_irq_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       tick;
    logic       per_flag;
    logic       irq_flag;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    int    en_mode = 0;   // 0: tb_en every cycle, 1: every third cycle
    bit    clr_auto = 1'b0;
    int    neg_cnt = 0;
    bit    done = 1'b0;

    // Reference model state
    int m_cnt = 0;
    bit m_tick = 0;
    bit m_per = 0;
    bit m_irq = 0;

    always #4 clk = ~clk;

    prd_irq_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tb_en     (tb_en),
        .rate_code (rate_code),
        .pie_en    (pie_en),
        .flag_clr  (flag_clr),
        .tick      (tick),
        .per_flag  (per_flag),
        .irq_flag  (irq_flag)
    );

    function automatic int period_of(input int code);
        int e = (code == 1 || code == 2) ? code + 7 : code;
        return 1 << (e - 1);
    endfunction

    // Drives the time-base pulse and the automatic clear strobes.
    always @(negedge clk) begin
        neg_cnt++;
        tb_en    = (en_mode == 0) ? 1'b1 : (neg_cnt % 3 == 0);
        flag_clr = clr_auto && (neg_cnt % 5 == 0);
    end

    // Reference model update at the edge, then comparison 2 ns later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tick = 0; m_per = 0; m_irq = 0;
        end else begin
            m_tick = 0;
            if (tb_en) begin
                m_cnt = (m_cnt + 1) % 32768;
                if (pie_en && rate_code != 0 && (m_cnt % period_of(rate_code)) == 0)
                    m_tick = 1;
            end
            if (m_tick) begin
                m_per = 1; m_irq = 1;
            end else if (flag_clr) begin
                m_per = 0; m_irq = 0;
            end
        end
        #2;
        if (!done) begin
            checks++;
            if (tick !== m_tick || per_flag !== m_per || irq_flag !== m_irq) begin
                errors++;
                $display("FAIL %s: actual tick=%b per=%b irq=%b expected tick=%b per=%b irq=%b",
                         cur_req, tick, per_flag, irq_flag, m_tick, m_per, m_irq);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Measures the number of cycles between two consecutive ticks.
    task automatic measure_gap(input int exp_gap, input string req);
        int n = 0;
        int guard = 0;
        do begin @(posedge clk); #2; guard++; end while (!tick && guard < 40000);
        do begin @(posedge clk); #2; n++; end while (!tick && n < 40000);
        checks++;
        if (n != exp_gap) begin
            errors++;
            $display("FAIL %s: tick gap actual=%0d expected=%0d", req, n, exp_gap);
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        rate_code = 4'd3; pie_en = 1'b1;
        run(4);
        checks++;
        if (tick !== 1'b0 || per_flag !== 1'b0 || irq_flag !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual tick=%b per=%b irq=%b expected 0 0 0", tick, per_flag, irq_flag);
        end
        rst_n = 1'b1;
        run(20);

        // R2: code 0 yields nothing
        cur_req = "R2";
        rate_code = 4'd0; pie_en = 1'b1; clr_auto = 1'b1;
        run(300);

        // R3: enable low blocks ticks
        cur_req = "R3";
        clr_auto = 1'b0;
        rate_code = 4'd3; pie_en = 1'b0;
        run(300);

        // R4: folded codes
        cur_req = "R4";
        pie_en = 1'b1;
        rate_code = 4'd1;
        measure_gap(128, "R4");
        rate_code = 4'd2;
        measure_gap(256, "R4");

        // R5: codes 3..15
        cur_req = "R5";
        for (int c = 3; c <= 15; c++) begin
            rate_code = 4'(c);
            run(5);
            measure_gap(1 << (c - 1), "R5");
        end
        // R8: flags left set by earlier ticks
        cur_req = "R8";
        rate_code = 4'd0;
        run(10);
        checks++;
        if (per_flag !== 1'b1 || irq_flag !== 1'b1) begin
            errors++;
            $display("FAIL R8: actual per=%b irq=%b expected 1 1", per_flag, irq_flag);
        end

        // R7: sparse time base
        cur_req = "R7";
        en_mode = 1;
        rate_code = 4'd3;
        run(300);
        en_mode = 0;

        // R9: clears colliding with ticks
        cur_req = "R9";
        clr_auto = 1'b1;
        rate_code = 4'd3;
        run(400);

        // R10 / R6: rate and enable changes without restart
        cur_req = "R10";
        for (int k = 0; k < 30; k++) begin
            rate_code = (k % 2 == 0) ? 4'd4 : 4'd7;
            pie_en = (k % 7 != 3);
            run(37);
        end
        cur_req = "R6";
        pie_en = 1'b1;
        rate_code = 4'd6;
        run(1000);
        clr_auto = 1'b0;
        run(40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule